// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block resolves the operand of a single load-type access. A request gives an addressing mode, a base register, an index register, a scale code, a signed 16-bit displacement/step and a literal. The block reads the base and index values from its own 32-entry register file and forms the effective address. It fetches the operand through a plain synchronous memory read port and returns the operand with a one-cycle completion pulse. Some modes write a new value back into the base register. That write-back lets a loop walk through an array without spending separate add instructions.

The modes with no memory access (literal and register) finish without touching memory. Plain, displacement, indexed, scaled, post-step and pre-update modes make one read. The pointer-chasing mode makes two reads in a row: the first returns a pointer and the second fetches the operand at that pointer. A base-selector flag swaps the register value for the program counter input, which gives PC-relative addressing. A fill port loads register entries from outside.

Top module: `operand_addr_gen`

## Requirements
- R1: After reset, reqReady is 1, done is 0 and memReq is 0.
- R2: Mode code 0 (literal) returns reqImm as the operand and issues no memory request. Codes 10 to 15 behave exactly like code 0.
- R3: Mode code 1 (register) returns the base register contents as the operand and issues no memory request.
- R4: Mode code 2 reads memory at the base register value. Mode code 3 reads at base plus the sign-extended 16-bit reqDisp. Each makes exactly one memory request, and the operand is the returned data.
- R5: Mode code 4 reads at base plus index register. Mode code 5 reads at base plus index shifted left by reqScale, where scale codes 0,1,2,3 mean factors 1,2,4,8.
- R6: Mode codes 6 (post-increment) and 7 (post-decrement) read at the unchanged base value. The base register is then increased (code 6) or decreased (code 7) by the sign-extended reqDisp.
- R7: Mode code 8 (pre-update) reads at base plus sign-extended reqDisp and writes that sum back into the base register.
- R8: Mode code 9 (memory indirect) makes two memory requests: the first at the base value, the second at the data the first returned. The operand is the data of the second read.
- R9: Register 0 always reads as zero. Write-back and fill writes to it have no effect.
- R10: When reqBaseIsPc is 1, pcValue replaces the base register value and no write-back happens.
- R11: A request is taken only while reqReady is 1. reqValid while busy is ignored.
- R12: done is high for exactly one cycle per accepted request. Any write-back is committed at the edge ending that cycle.
- R13: With rfWrEn high, rfWrData is written to entry rfWrIdx at the clock edge. A write-back at the same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request will be taken |
| reqMode | input | 4 | Addressing mode code |
| reqBase | input | 5 | Base register number |
| reqIndex | input | 5 | Index register number |
| reqScale | input | 2 | Scale code for mode 5 |
| reqDisp | input | 16 | Signed displacement or step |
| reqImm | input | 32 | Literal operand |
| reqBaseIsPc | input | 1 | Use pcValue as base |
| pcValue | input | 32 | Program counter value |
| rfWrEn | input | 1 | Register fill enable |
| rfWrIdx | input | 5 | Register fill index |
| rfWrData | input | 32 | Register fill data |
| memReq | output | 1 | Memory read request, one cycle |
| memAddr | output | 32 | Memory read address |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| done | output | 1 | Operand ready pulse |
| operand | output | 32 | Resolved operand |

## Verification
The assertions rely on the memory answering each memReq with exactly one memRvalid pulse, and on no response arriving without an outstanding request. The stimulus respects this with a memory model that returns data once, one or two cycles after each request. The test keeps fill writes away from cycles in which an access completes, so precedence never decides a checked value. Requests are raised only when reqReady is seen, except in one deliberate case that holds reqValid through a busy window to show it is ignored.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    MODE_LIT    = 4'd0,
    MODE_REG    = 4'd1,
    MODE_RIND   = 4'd2,
    MODE_BDISP  = 4'd3,
    MODE_BIDX   = 4'd4,
    MODE_SCALED = 4'd5,
    MODE_POSTINC= 4'd6,
    MODE_POSTDEC= 4'd7,
    MODE_PREUPD = 4'd8,
    MODE_INDIR  = 4'd9
  } agu_mode_e;

  typedef struct packed {
    logic capture;    // take request fields, compute address
    logic latchPtr;   // first indirect read returned a pointer
    logic latchData;  // operand returned from memory
    logic writeBack;  // commit base register update
  } agu_ctrl_t;

endpackage

// File: rtl/agu_datapath.sv
module agu_datapath
  import agu_pkg::*;
#(
  parameter int DataW    = 32,
  parameter int RegCount = 32,
  parameter int DispW    = 16,
  localparam int IdxW    = $clog2(RegCount)
) (
  input  logic             clk,
  input  logic             rstN,
  input  agu_ctrl_t        ctrl,
  input  logic [3:0]       reqMode,
  input  logic [IdxW-1:0]  reqBase,
  input  logic [IdxW-1:0]  reqIndex,
  input  logic [1:0]       reqScale,
  input  logic [DispW-1:0] reqDisp,
  input  logic [DataW-1:0] reqImm,
  input  logic             reqBaseIsPc,
  input  logic [DataW-1:0] pcValue,
  input  logic             rfWrEn,
  input  logic [IdxW-1:0]  rfWrIdx,
  input  logic [DataW-1:0] rfWrData,
  input  logic [DataW-1:0] memRdata,
  output logic [DataW-1:0] memAddr,
  output logic [DataW-1:0] operand,
  output logic             needMem,
  output logic             isIndirect
);

  logic [DataW-1:0] rf [RegCount];
  logic [DataW-1:0] baseVal, idxVal, dispExt;
  logic [DataW-1:0] addrNext, opNext, wbNext;
  logic             wbNextEn;
  logic [DataW-1:0] addrReg, opReg, wbVal;
  logic [IdxW-1:0]  wbIdx;
  logic             wbEn, indReg;
  agu_mode_e        modeSel;

  assign modeSel = agu_mode_e'(reqMode);
  assign baseVal = reqBaseIsPc ? pcValue : rf[reqBase];
  assign idxVal  = rf[reqIndex];
  assign dispExt = {{(DataW-DispW){reqDisp[DispW-1]}}, reqDisp};

  always_comb begin
    addrNext = baseVal;
    opNext   = reqImm;
    wbNext   = baseVal;
    wbNextEn = 1'b0;
    needMem  = 1'b1;
    unique case (modeSel)
      MODE_REG:     begin opNext = baseVal; needMem = 1'b0; end
      MODE_RIND:    addrNext = baseVal;
      MODE_BDISP:   addrNext = baseVal + dispExt;
      MODE_BIDX:    addrNext = baseVal + idxVal;
      MODE_SCALED:  addrNext = baseVal + (idxVal << reqScale);
      MODE_POSTINC: begin wbNext = baseVal + dispExt; wbNextEn = 1'b1; end
      MODE_POSTDEC: begin wbNext = baseVal - dispExt; wbNextEn = 1'b1; end
      MODE_PREUPD:  begin
        addrNext = baseVal + dispExt;
        wbNext   = baseVal + dispExt;
        wbNextEn = 1'b1;
      end
      MODE_INDIR:   addrNext = baseVal;
      default:      needMem = 1'b0;  // literal and unused codes
    endcase
    if (reqBaseIsPc || reqBase == '0) wbNextEn = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      opReg   <= '0;
      wbVal   <= '0;
      wbIdx   <= '0;
      wbEn    <= 1'b0;
      indReg  <= 1'b0;
    end else begin
      if (ctrl.capture) begin
        addrReg <= addrNext;
        opReg   <= opNext;
        wbVal   <= wbNext;
        wbIdx   <= reqBase;
        wbEn    <= wbNextEn;
        indReg  <= (modeSel == MODE_INDIR);
      end
      if (ctrl.latchPtr)  addrReg <= memRdata;
      if (ctrl.latchData) opReg   <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RegCount; i++) rf[i] <= '0;
    end else if (ctrl.writeBack && wbEn) begin
      rf[wbIdx] <= wbVal;
    end else if (rfWrEn && rfWrIdx != '0) begin
      rf[rfWrIdx] <= rfWrData;
    end
  end

  assign memAddr    = addrReg;
  assign operand    = opReg;
  assign isIndirect = indReg;

  // R9: entry 0 keeps its zero value whatever writes are attempted
  assert_r0_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rf[0] == '0);

endmodule

// File: rtl/agu_control.sv
module agu_control
  import agu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      needMem,
  input  logic      isIndirect,
  input  logic      memRvalid,
  output logic      reqReady,
  output logic      memReq,
  output logic      done,
  output agu_ctrl_t ctrl
);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_FIN} agu_state_e;

  agu_state_e state, stateNext;
  logic       ptrTaken;

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctrl.capture = 1'b1;
        stateNext    = needMem ? ST_ISSUE : ST_FIN;
      end
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT: if (memRvalid) begin
        if (isIndirect && !ptrTaken) begin
          ctrl.latchPtr = 1'b1;
          stateNext     = ST_ISSUE;
        end else begin
          ctrl.latchData = 1'b1;
          stateNext      = ST_FIN;
        end
      end
      ST_FIN: begin
        ctrl.writeBack = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ptrTaken <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctrl.capture)       ptrTaken <= 1'b0;
      else if (ctrl.latchPtr) ptrTaken <= 1'b1;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_ISSUE);
  assign done     = (state == ST_FIN);

  // R12: completion is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R11: the block is ready again right after completing
  assert_ready_after_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> reqReady);
  // R4: each memory request lasts one cycle
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);
  // R2: accepted access without memory completes next cycle with no request
  assert_nomem_fast_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !needMem) |=> (done && !memReq));
  // R11: a new request is never taken while busy
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && !done) |=> !reqReady);

endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import agu_pkg::*;
#(
  parameter int DataW    = 32,
  parameter int RegCount = 32,
  parameter int DispW    = 16,
  localparam int IdxW    = $clog2(RegCount)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [3:0]       reqMode,
  input  logic [IdxW-1:0]  reqBase,
  input  logic [IdxW-1:0]  reqIndex,
  input  logic [1:0]       reqScale,
  input  logic [DispW-1:0] reqDisp,
  input  logic [DataW-1:0] reqImm,
  input  logic             reqBaseIsPc,
  input  logic [DataW-1:0] pcValue,
  input  logic             rfWrEn,
  input  logic [IdxW-1:0]  rfWrIdx,
  input  logic [DataW-1:0] rfWrData,
  output logic             memReq,
  output logic [DataW-1:0] memAddr,
  input  logic             memRvalid,
  input  logic [DataW-1:0] memRdata,
  output logic             done,
  output logic [DataW-1:0] operand
);

  agu_ctrl_t ctrl;
  logic      needMem, isIndirect;

  agu_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .needMem    (needMem),
    .isIndirect (isIndirect),
    .memRvalid  (memRvalid),
    .reqReady   (reqReady),
    .memReq     (memReq),
    .done       (done),
    .ctrl       (ctrl)
  );

  agu_datapath #(
    .DataW    (DataW),
    .RegCount (RegCount),
    .DispW    (DispW)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .reqMode     (reqMode),
    .reqBase     (reqBase),
    .reqIndex    (reqIndex),
    .reqScale    (reqScale),
    .reqDisp     (reqDisp),
    .reqImm      (reqImm),
    .reqBaseIsPc (reqBaseIsPc),
    .pcValue     (pcValue),
    .rfWrEn      (rfWrEn),
    .rfWrIdx     (rfWrIdx),
    .rfWrData    (rfWrData),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .operand     (operand),
    .needMem     (needMem),
    .isIndirect  (isIndirect)
  );

endmodule

// File: tb/test_operand_addr_gen.sv
module test_operand_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqMode = '0;
  logic [4:0]  reqBase = '0, reqIndex = '0;
  logic [1:0]  reqScale = '0;
  logic [15:0] reqDisp = '0;
  logic [31:0] reqImm = '0;
  logic        reqBaseIsPc = 1'b0;
  logic [31:0] pcValue = 32'h0000_0400;
  logic        rfWrEn = 1'b0;
  logic [4:0]  rfWrIdx = '0;
  logic [31:0] rfWrData = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRvalid = 1'b0;
  logic [31:0] memRdata = '0;
  logic        done;
  logic [31:0] operand;

  int vecCount = 0, failCount = 0, memReqCount = 0, memLat = 1;
  bit finished = 0;
  logic [31:0] model [32];
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;  // 250 MHz

  operand_addr_gen i_operand_addr_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqMode(reqMode), .reqBase(reqBase), .reqIndex(reqIndex),
    .reqScale(reqScale), .reqDisp(reqDisp), .reqImm(reqImm),
    .reqBaseIsPc(reqBaseIsPc), .pcValue(pcValue), .rfWrEn(rfWrEn),
    .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .memReq(memReq),
    .memAddr(memAddr), .memRvalid(memRvalid), .memRdata(memRdata),
    .done(done), .operand(operand));

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_0F96;
  endfunction

  // memory model: one response per request, after memLat cycles
  logic [31:0] pendAddr = '0;
  int          pendCnt = 0;
  always @(posedge clk) begin
    memRvalid <= 1'b0;
    if (pendCnt == 1) begin
      memRvalid <= 1'b1;
      memRdata  <= memFn(pendAddr);
    end
    if (pendCnt > 0) pendCnt <= pendCnt - 1;
    if (memReq) begin
      pendAddr    <= memAddr;
      pendCnt     <= memLat;
      memReqCount <= memReqCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every completion (R12 single pulse)
  bit prevDone = 0;
  always @(negedge clk) begin
    if (rstN && done) begin
      if (prevDone) check(0, "R12 done longer than one cycle", 32'd1, 32'd0);
      if (expQ.size() == 0) check(0, "R11/R12 unexpected done", operand, 32'd0);
      else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(operand == e, t, operand, e);
      end
    end
    prevDone = done;
  end

  task automatic rfLoad(input int idx, input logic [31:0] val);
    @(negedge clk);
    rfWrEn = 1'b1; rfWrIdx = 5'(idx); rfWrData = val;
    @(negedge clk);
    rfWrEn = 1'b0;
    if (idx != 0) model[idx] = val;
  endtask

  task automatic predict(input int mode, input int b, input int x, input int scale,
                         input logic [15:0] disp, input logic [31:0] imm, input bit usePc,
                         output logic [31:0] exp, output int nReq);
    logic [31:0] base, idxv, dext, addr, nv;
    bit wb;
    base = usePc ? pcValue : model[b];
    idxv = model[x];
    dext = {{16{disp[15]}}, disp};
    addr = base; nv = base; wb = 0; nReq = 1;
    case (mode)
      1: begin exp = base; nReq = 0; end
      2: addr = base;
      3: addr = base + dext;
      4: addr = base + idxv;
      5: addr = base + (idxv << scale);
      6: begin addr = base; nv = base + dext; wb = 1; end
      7: begin addr = base; nv = base - dext; wb = 1; end
      8: begin addr = base + dext; nv = addr; wb = 1; end
      9: begin exp = memFn(memFn(base)); nReq = 2; end
      default: begin exp = imm; nReq = 0; end
    endcase
    if (mode >= 2 && mode <= 8) exp = memFn(addr);
    if (wb && !usePc && b != 0) model[b] = nv;
  endtask

  task automatic access(input int mode, input int b, input int x, input int scale,
                        input logic [15:0] disp, input logic [31:0] imm, input bit usePc,
                        input string tag);
    logic [31:0] exp;
    int nReq, startReq;
    while (!reqReady) @(negedge clk);
    predict(mode, b, x, scale, disp, imm, usePc, exp, nReq);
    expQ.push_back(exp); tagQ.push_back(tag);
    startReq = memReqCount;
    reqMode = 4'(mode); reqBase = 5'(b); reqIndex = 5'(x); reqScale = 2'(scale);
    reqDisp = disp; reqImm = imm; reqBaseIsPc = usePc; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    do @(negedge clk); while (!reqReady);
    check(memReqCount - startReq == nReq, {tag, " memory request count"},
          32'(memReqCount - startReq), 32'(nReq));
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 reqReady in reset", 32'(reqReady), 32'd1);
    check(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
    check(memReq == 1'b0, "R1 memReq in reset", 32'(memReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && done == 1'b0, "R1 idle after reset", 32'(reqReady), 32'd1);

    // R13 fill port
    rfLoad(1, 32'h0000_1000);
    rfLoad(2, 32'h0000_0020);
    rfLoad(3, 32'h0000_0003);
    rfLoad(5, 32'h0000_2000);
    rfLoad(7, 32'h0000_3000);
    rfLoad(0, 32'hDEAD_BEEF);
    access(1, 2, 0, 0, 16'h0, 32'h0, 0, "R13 fill then register read");

    access(0, 0, 0, 0, 16'h0, 32'hCAFE_0001, 0, "R2 literal");
    access(12, 0, 0, 0, 16'h0, 32'h1234_5678, 0, "R2 unused code as literal");
    access(1, 1, 0, 0, 16'h0, 32'h0, 0, "R3 register mode");
    access(1, 0, 0, 0, 16'h0, 32'h0, 0, "R9 r0 reads zero after fill");
    access(2, 1, 0, 0, 16'h0, 32'h0, 0, "R4 register indirect");
    access(3, 1, 0, 0, 16'h0040, 32'h0, 0, "R4 displacement positive");
    access(3, 1, 0, 0, 16'hFFF8, 32'h0, 0, "R4 displacement negative");
    access(4, 1, 2, 0, 16'h0, 32'h0, 0, "R5 base plus index");
    for (int s = 0; s < 4; s++)
      access(5, 1, 3, s, 16'h0, 32'h0, 0, $sformatf("R5 scaled index code %0d", s));
    access(6, 5, 0, 0, 16'h0004, 32'h0, 0, "R6 post-increment access");
    access(1, 5, 0, 0, 16'h0, 32'h0, 0, "R6 post-increment base updated");
    access(7, 5, 0, 0, 16'h0008, 32'h0, 0, "R6 post-decrement access");
    access(1, 5, 0, 0, 16'h0, 32'h0, 0, "R6 post-decrement base updated");
    access(8, 1, 0, 0, 16'h0010, 32'h0, 0, "R7 pre-update first");
    access(8, 1, 0, 0, 16'h0010, 32'h0, 0, "R7 pre-update second iteration");
    access(1, 1, 0, 0, 16'h0, 32'h0, 0, "R7 pre-update base value");
    access(9, 2, 0, 0, 16'h0, 32'h0, 0, "R8 memory indirect");
    access(6, 0, 0, 0, 16'h0004, 32'h0, 0, "R9 post-increment on r0");
    access(1, 0, 0, 0, 16'h0, 32'h0, 0, "R9 r0 unchanged by write-back");
    access(3, 0, 0, 0, 16'h0010, 32'h0, 1, "R10 PC-relative displacement");
    access(6, 7, 0, 0, 16'h0004, 32'h0, 1, "R10 PC base post-increment");
    access(1, 7, 0, 0, 16'h0, 32'h0, 0, "R10 register untouched with PC base");

    // R11: reqValid held while busy must be ignored
    begin
      logic [31:0] exp;
      int nReq, startReq;
      predict(3, 1, 0, 0, 16'h0004, 32'h0, 0, exp, nReq);
      expQ.push_back(exp); tagQ.push_back("R11 access with held request");
      startReq = memReqCount;
      reqMode = 4'd3; reqBase = 5'd1; reqDisp = 16'h0004; reqBaseIsPc = 1'b0;
      reqValid = 1'b1;
      @(negedge clk);
      reqMode = 4'd0; reqImm = 32'hBAD0_BAD0;
      @(negedge clk);
      @(negedge clk);
      reqValid = 1'b0;
      do @(negedge clk); while (!reqReady);
      repeat (2) @(negedge clk);
      check(memReqCount - startReq == 1, "R11 busy request ignored",
            32'(memReqCount - startReq), 32'd1);
      check(expQ.size() == 0, "R11 no extra completion", 32'(expQ.size()), 32'd0);
    end

    // longer memory latency
    memLat = 2;
    access(9, 1, 0, 0, 16'h0, 32'h0, 0, "R8 memory indirect slow memory");
    access(5, 1, 2, 3, 16'h0, 32'h0, 0, "R5 scaled slow memory");
    access(7, 2, 0, 0, 16'h0002, 32'h0, 0, "R6 post-decrement slow memory");
    access(1, 2, 0, 0, 16'h0, 32'h0, 0, "R12 write-back visible after done");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R12 all completions seen", 32'(expQ.size()), 32'd0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule